// File: doc/BRIEF.md
# Segment Relocation and Limit-Check Unit

This unit turns a segment-relative memory reference into a flat linear address. Each of the six segment registers has a hidden descriptor copy holding a base, a limit and two attribute bits. Every later access reads only that copy, so no descriptor is fetched from a table per access. A load port fills an entry. In protected mode the whole descriptor is copied. In real mode only the base is rebuilt from the selector. The old limit and attributes stay, so a large limit set up earlier in protected mode survives a return to real mode.

An address request names a segment and gives an effective address. That address is built from an optional base register, an optional index register shifted left by a scale, and a displacement. The unit adds the segment base to the effective address. It compares the accessed byte range against the cached limit in the same stage, and the comparison does not use the sum. A request with at most two non-zero terms produces its result one cycle after it is presented. A request that uses base, index and a non-zero displacement takes one extra cycle. The result comes out as a valid strobe, a linear address and a fault flag.

Top module: `seg_reloc_unit`

## Requirements
- R1: After reset every entry holds base 0, limit 0x0000FFFF and attributes present and writable, and `out_valid` is low.
- R2: A protected-mode load (`ld_prot`=1) whose attribute bit 0 (present) is set replaces the entry's base, limit and attributes. Attribute bit 1 means writable. All later requests use the new values.
- R3: A real-mode load (`ld_prot`=0) sets the entry's base to the 16-bit selector shifted left by 4. The limit and attributes are left unchanged.
- R4: A protected-mode load with attribute bit 0 clear leaves the entry exactly as it was.
- R5: `out_lin` equals the segment base plus the effective address, modulo 2^32. The effective address is base register (if `req_use_base`) plus index register shifted left by `req_scale` (if `req_use_index`) plus displacement. The scale codes 0 to 3 give factors 1, 2, 4 and 8.
- R6: A request with `req_use_base`=1, `req_use_index`=1 and a non-zero displacement gives its result two cycles after it is presented. Any other request gives its result one cycle after it is presented. No request may be presented in the cycle right after such a three-term request.
- R7: `out_fault` is set when effective address + size − 1 exceeds the limit. This sum is taken 33 bits wide, so an access that wraps past 2^32 faults. `req_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. `out_valid` still pulses on a fault, and `out_lin` is then undefined.
- R8: A write (`req_write`=1) to an entry whose writable bit is clear sets `out_fault`. A read of that entry does not.
- R9: When a load and a request name the same segment in the same cycle, the request uses the descriptor as it stood before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Descriptor load strobe |
| ld_prot | input | 1 | 1 = protected-mode load, 0 = real-mode load |
| ld_seg | input | 3 | Segment register index, 0 to 5 |
| ld_sel | input | 16 | Selector value |
| ld_base | input | 32 | Descriptor base (protected mode) |
| ld_limit | input | 32 | Descriptor limit (protected mode) |
| ld_attr | input | 2 | Bit 0 present, bit 1 writable |
| req_valid | input | 1 | Address request strobe |
| req_seg | input | 3 | Segment register index, 0 to 5 |
| req_use_base | input | 1 | Include base register term |
| req_use_index | input | 1 | Include scaled index term |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_scale | input | 2 | Index shift amount 0 to 3 |
| req_disp | input | 32 | Displacement |
| req_size | input | 2 | Access size code, 2^code bytes |
| req_write | input | 1 | 1 = write access |
| out_valid | output | 1 | Result strobe |
| out_lin | output | 32 | Linear address |
| out_fault | output | 1 | Limit or write-protection fault |

## Verification
A descriptor load and an address request can fall in the same cycle and name the same segment. The bench drives both in one cycle: the load replaces segment 0 with a new base and a small limit, and the request targets segment 0. The result must carry the old base and no fault. The next two requests must show the new base and the new, smaller limit, which proves the load took effect one cycle later. Three-term requests are also sampled in the cycle between request and result, where the strobe must still be low.

// File: rtl/seg_pkg.sv
package seg_pkg;
  parameter int ADDR_W = 32;

  typedef struct packed {
    logic writable;
    logic present;
  } seg_attr_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    seg_attr_t         attr;
  } seg_desc_t;
endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_pkg::*;
#(
  parameter int NSEG       = 6,
  parameter int SEL_W      = 16,
  parameter int REAL_SHIFT = 4,
  parameter logic [ADDR_W-1:0] RST_LIMIT = 32'h0000_FFFF,
  localparam int SEG_W     = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic             ld_prot,
  input  logic [SEG_W-1:0] ld_seg,
  input  logic [SEL_W-1:0] ld_sel,
  input  seg_desc_t        ld_desc,
  input  logic [SEG_W-1:0] rd_seg,
  output seg_desc_t        rd_desc
);
  logic [ADDR_W-1:0] real_base;
  seg_desc_t ent [NSEG];

  assign real_base = {{(ADDR_W-SEL_W){1'b0}}, ld_sel} << REAL_SHIFT;

  for (genvar i = 0; i < NSEG; i++) begin : g_ent
    seg_desc_t q;
    logic      hit;
    assign hit    = ld_valid && (ld_seg == SEG_W'(i));
    assign ent[i] = q;

    always_ff @(posedge clk) begin
      if (rst) begin
        q.base          <= '0;
        q.limit         <= RST_LIMIT;
        q.attr.present  <= 1'b1;
        q.attr.writable <= 1'b1;
      end else if (hit) begin
        if (!ld_prot)                 q.base <= real_base;
        else if (ld_desc.attr.present) q      <= ld_desc;
      end
    end

    // rejected protected load must not disturb the entry
    assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (rst)
      hit && ld_prot && !ld_desc.attr.present |=> $stable(q));
    // real-mode load keeps limit and attributes
    assert_real_keeps_limit_R3: assert property (@(posedge clk) disable iff (rst)
      hit && !ld_prot |=> $stable(q.limit) && $stable(q.attr));
  end

  always_comb begin
    rd_desc = ent[0];
    for (int i = 1; i < NSEG; i++)
      if (rd_seg == SEG_W'(i)) rd_desc = ent[i];
  end
endmodule

// File: rtl/seg_ea_stage.sv
module seg_ea_stage
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_use_base,
  input  logic              req_use_index,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [ADDR_W-1:0] req_index,
  input  logic [1:0]        req_scale,
  input  logic [ADDR_W-1:0] req_disp,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  seg_desc_t         req_desc,
  output logic              long_op,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea,
  output seg_desc_t         ea_desc,
  output logic [1:0]        ea_size,
  output logic              ea_write
);
  logic [ADDR_W-1:0] scaled, op_a, op_b, sum0;
  logic              p_valid;
  logic [ADDR_W-1:0] p_sum, p_disp;
  seg_desc_t         p_desc;
  logic [1:0]        p_size;
  logic              p_write;

  assign scaled  = req_index << req_scale;
  assign long_op = req_use_base && req_use_index && (req_disp != '0);
  assign op_a    = req_use_base ? req_base : (req_use_index ? scaled : '0);
  assign op_b    = (req_use_base && req_use_index) ? scaled : req_disp;
  assign sum0    = op_a + op_b;

  always_ff @(posedge clk) begin
    if (rst) p_valid <= 1'b0;
    else     p_valid <= req_valid && long_op;
    p_sum   <= sum0;
    p_disp  <= req_disp;
    p_desc  <= req_desc;
    p_size  <= req_size;
    p_write <= req_write;
  end

  always_comb begin
    if (p_valid) begin
      ea_valid = 1'b1;
      ea       = p_sum + p_disp;
      ea_desc  = p_desc;
      ea_size  = p_size;
      ea_write = p_write;
    end else begin
      ea_valid = req_valid && !long_op;
      ea       = sum0;
      ea_desc  = req_desc;
      ea_size  = req_size;
      ea_write = req_write;
    end
  end

  // usage rule: no request in the cycle after a three-term request
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    p_valid |-> !req_valid);
endmodule

// File: rtl/seg_limit_reloc.sv
module seg_limit_reloc
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ea_valid,
  input  logic [ADDR_W-1:0] ea,
  input  seg_desc_t         ea_desc,
  input  logic [1:0]        ea_size,
  input  logic              ea_write,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_lin,
  output logic              out_fault
);
  logic [ADDR_W:0] extra, last_byte;
  logic            over_limit, ro_write;

  always_comb begin
    extra      = '0;
    extra[3:0] = (4'd1 << ea_size) - 4'd1;
  end

  // limit side works on the effective address only, beside the base adder
  assign last_byte  = {1'b0, ea} + extra;
  assign over_limit = last_byte > {1'b0, ea_desc.limit};
  assign ro_write   = ea_write && !ea_desc.attr.writable;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= ea_valid;
    out_lin   <= ea_desc.base + ea;
    out_fault <= over_limit || ro_write;
  end

  assert_strobe_on_fault_R7: assert property (@(posedge clk) disable iff (rst)
    ea_valid |=> out_valid);
  assert_ro_write_faults_R8: assert property (@(posedge clk) disable iff (rst)
    ea_valid && ea_write && !ea_desc.attr.writable |=> out_fault);
endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
  import seg_pkg::*;
#(
  parameter int NSEG       = 6,
  parameter int SEL_W      = 16,
  parameter int REAL_SHIFT = 4,
  parameter logic [31:0] RST_LIMIT = 32'h0000_FFFF,
  localparam int SEG_W     = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic             ld_prot,
  input  logic [SEG_W-1:0] ld_seg,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [31:0]      ld_base,
  input  logic [31:0]      ld_limit,
  input  logic [1:0]       ld_attr,
  input  logic             req_valid,
  input  logic [SEG_W-1:0] req_seg,
  input  logic             req_use_base,
  input  logic             req_use_index,
  input  logic [31:0]      req_base,
  input  logic [31:0]      req_index,
  input  logic [1:0]       req_scale,
  input  logic [31:0]      req_disp,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  output logic             out_valid,
  output logic [31:0]      out_lin,
  output logic             out_fault
);
  seg_desc_t         ld_desc, rd_desc, ea_desc;
  logic              long_op, ea_valid, ea_write;
  logic [ADDR_W-1:0] ea;
  logic [1:0]        ea_size;

  assign ld_desc.base  = ld_base;
  assign ld_desc.limit = ld_limit;
  assign ld_desc.attr  = seg_attr_t'(ld_attr);

  seg_desc_cache #(
    .NSEG(NSEG), .SEL_W(SEL_W), .REAL_SHIFT(REAL_SHIFT), .RST_LIMIT(RST_LIMIT)
  ) i_cache (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_prot(ld_prot),
    .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_desc(ld_desc),
    .rd_seg(req_seg), .rd_desc(rd_desc)
  );

  seg_ea_stage i_ea (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .req_use_base(req_use_base), .req_use_index(req_use_index),
    .req_base(req_base), .req_index(req_index), .req_scale(req_scale),
    .req_disp(req_disp), .req_size(req_size), .req_write(req_write),
    .req_desc(rd_desc), .long_op(long_op), .ea_valid(ea_valid), .ea(ea),
    .ea_desc(ea_desc), .ea_size(ea_size), .ea_write(ea_write)
  );

  seg_limit_reloc i_chk (
    .clk(clk), .rst(rst), .ea_valid(ea_valid), .ea(ea), .ea_desc(ea_desc),
    .ea_size(ea_size), .ea_write(ea_write),
    .out_valid(out_valid), .out_lin(out_lin), .out_fault(out_fault)
  );

  assert_short_latency_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid && !long_op |=> out_valid);
  assert_long_latency_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid && long_op |=> !out_valid);
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/test_seg_reloc_unit.sv
`timescale 1ns/1ps
module test_seg_reloc_unit;
  logic clk = 1'b0, rst = 1'b1;
  logic ld_valid = 0, ld_prot = 0;
  logic [2:0] ld_seg = 0;
  logic [15:0] ld_sel = 0;
  logic [31:0] ld_base = 0, ld_limit = 0;
  logic [1:0] ld_attr = 0;
  logic req_valid = 0, req_use_base = 0, req_use_index = 0, req_write = 0;
  logic [2:0] req_seg = 0;
  logic [31:0] req_base = 0, req_index = 0, req_disp = 0;
  logic [1:0] req_scale = 0, req_size = 0;
  logic out_valid, out_fault;
  logic [31:0] out_lin;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  seg_reloc_unit i_seg_reloc_unit (.*);

  typedef struct packed {
    logic [2:0] seg; logic ub; logic ui;
    logic [31:0] base; logic [31:0] idx; logic [1:0] sc; logic [31:0] disp;
    logic [1:0] sz; logic wr; logic [31:0] lin; logic fault;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{3'd0,1'b1,1'b0,32'h100,32'h0,2'd0,32'h20,2'd2,1'b0,32'h120,1'b0},
    '{3'd0,1'b0,1'b1,32'h0,32'h10,2'd3,32'h0,2'd0,1'b1,32'h80,1'b0},
    '{3'd0,1'b0,1'b0,32'h0,32'h0,2'd0,32'hFFFF,2'd0,1'b0,32'hFFFF,1'b0},
    '{3'd0,1'b0,1'b0,32'h0,32'h0,2'd0,32'hFFFE,2'd1,1'b0,32'hFFFE,1'b0},
    '{3'd0,1'b0,1'b0,32'h0,32'h0,2'd0,32'hFFFE,2'd2,1'b0,32'h0,1'b1},
    '{3'd1,1'b1,1'b1,32'h10,32'h4,2'd2,32'h100,2'd2,1'b0,32'h1000_0120,1'b0},
    '{3'd1,1'b0,1'b0,32'h0,32'h0,2'd0,32'h1000,2'd0,1'b0,32'h0,1'b1},
    '{3'd2,1'b0,1'b0,32'h0,32'h0,2'd0,32'hFFFF_FFFD,2'd1,1'b0,32'h0001_FFFD,1'b0},
    '{3'd2,1'b0,1'b0,32'h0,32'h0,2'd0,32'hFFFF_FFFD,2'd2,1'b0,32'h0,1'b1},
    '{3'd2,1'b0,1'b0,32'h0,32'h0,2'd0,32'h0,2'd0,1'b1,32'h0,1'b1},
    '{3'd3,1'b0,1'b1,32'h0,32'h2,2'd1,32'h0,2'd0,1'b0,32'h12344,1'b0},
    '{3'd1,1'b1,1'b1,32'hE00,32'h40,2'd2,32'hFF,2'd0,1'b1,32'h1000_0FFF,1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] seg, input logic prot, input logic [15:0] sel,
                         input logic [31:0] base, input logic [31:0] lim, input logic [1:0] attr);
    @(negedge clk);
    ld_valid = 1; ld_seg = seg; ld_prot = prot; ld_sel = sel;
    ld_base = base; ld_limit = lim; ld_attr = attr;
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic drive_req(input vec_t v);
    req_valid = 1; req_seg = v.seg; req_use_base = v.ub; req_use_index = v.ui;
    req_base = v.base; req_index = v.idx; req_scale = v.sc; req_disp = v.disp;
    req_size = v.sz; req_write = v.wr;
  endtask

  task automatic judge(input string tag, input vec_t v);
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " fault"}, 32'(out_fault), 32'(v.fault));
    if (!v.fault) chk({tag, " lin"}, out_lin, v.lin);
  endtask

  task automatic do_req(input string tag, input vec_t v);
    @(negedge clk);
    drive_req(v);
    @(negedge clk);
    req_valid = 0;
    if (v.ub && v.ui && v.disp != 0) begin
      chk({tag, " R6 mid-cycle valid"}, 32'(out_valid), 32'd0);
      @(negedge clk);
    end
    judge(tag, v);
  endtask

  function automatic vec_t mk(input logic [2:0] seg, input logic [31:0] disp,
                              input logic [1:0] sz, input logic wr,
                              input logic [31:0] lin, input logic fault);
    vec_t v;
    v = '0; v.seg = seg; v.disp = disp; v.sz = sz; v.wr = wr; v.lin = lin; v.fault = fault;
    return v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", 32'(out_valid), 32'd0);
    rst = 0;
    @(negedge clk);
    chk("R1 valid low after reset", 32'(out_valid), 32'd0);
    do_req("R1 reset limit top byte", mk(3'd4, 32'hFFFF, 2'd0, 1'b0, 32'hFFFF, 1'b0));
    do_req("R1 reset limit exceeded", mk(3'd4, 32'h1_0000, 2'd0, 1'b0, 32'h0, 1'b1));
    do_req("R1 reset writable", mk(3'd4, 32'h40, 2'd0, 1'b1, 32'h40, 1'b0));

    // R2 protected loads, R3 real-mode load
    do_load(3'd1, 1'b1, 16'h0008, 32'h1000_0000, 32'h0000_0FFF, 2'b11);
    do_load(3'd2, 1'b1, 16'h0010, 32'h0002_0000, 32'hFFFF_FFFF, 2'b01);
    do_load(3'd3, 1'b0, 16'h1234, 32'h0, 32'h0, 2'b00);

    // table: R2 R3 R5 R6 R7 R8
    for (int k = 0; k < 12; k++) do_req($sformatf("R5/R7 vector %0d", k), VEC[k]);

    // R4 rejected load: not present
    do_load(3'd1, 1'b1, 16'h0018, 32'hDEAD_0000, 32'hFFFF_FFFF, 2'b10);
    do_req("R4 base kept", mk(3'd1, 32'h10, 2'd0, 1'b0, 32'h1000_0010, 1'b0));
    do_req("R4 limit kept", mk(3'd1, 32'h1000, 2'd0, 1'b0, 32'h0, 1'b1));

    // R3 real load keeps a large limit
    do_load(3'd5, 1'b1, 16'h0020, 32'h0, 32'hFFFF_FFFF, 2'b11);
    do_load(3'd5, 1'b0, 16'h0010, 32'h0, 32'h0, 2'b00);
    do_req("R3 large limit kept", mk(3'd5, 32'h2_0000, 2'd2, 1'b1, 32'h0002_0100, 1'b0));

    // R9 load and request on the same segment in the same cycle
    @(negedge clk);
    ld_valid = 1; ld_seg = 3'd0; ld_prot = 1; ld_base = 32'h5000_0000;
    ld_limit = 32'h0000_00FF; ld_attr = 2'b11;
    drive_req(mk(3'd0, 32'h200, 2'd0, 1'b0, 32'h200, 1'b0));
    @(negedge clk);
    ld_valid = 0; req_valid = 0;
    judge("R9 old descriptor used", mk(3'd0, 32'h200, 2'd0, 1'b0, 32'h200, 1'b0));
    do_req("R9 new limit", mk(3'd0, 32'h200, 2'd0, 1'b0, 32'h0, 1'b1));
    do_req("R9 new base", mk(3'd0, 32'h10, 2'd0, 1'b0, 32'h5000_0010, 1'b0));

    @(negedge clk);
    chk("R6 strobe drops when idle", 32'(out_valid), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule